// File: doc/BRIEF.md
# Compare Match Interval Timer

A single-channel interval timer for periodic event generation. A 16-bit up-counter advances by one on each tick of a prescaler, but only while a run bit is set. Software picks one of four prescale divisors of the system clock with a 2-bit select field. When the counter already holds the value of a programmable compare constant and a tick arrives, the counter goes back to zero and a sticky match flag is set. The match period is therefore (constant + 1) times the divisor. An interrupt output follows the flag whenever the interrupt enable bit is set.

Software reaches four registers through a plain register bus with address, write data, write strobe, read strobe and read data: a run register, a control/status register, the counter and the compare constant. Two power inputs act on the timer. A module-standby input freezes the timer and blocks register writes, and the constant is kept. A deep-standby input restores the constant to all ones.

Top module: `match_interval_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the constant reads 0xFFFF, the run and control/status registers read 0, and the interrupt output is low.
- R2: Address 0 holds the run bit at bit 0. Address 1 is control/status, with the match flag at bit 7, the interrupt enable at bit 6 and the clock select at bits 1:0. Address 2 is the counter and address 3 is the constant. The counter and the constant read back all 16 bits that were written. Read data is 0 while the read strobe is low.
- R3: The counter increases by exactly one per prescaler tick while the run bit is 1, and never otherwise. The prescaler is held at zero while the run bit is 0, so k clock edges after the edge that sets the run bit, the counter has advanced by floor(k/N) for divisor N.
- R4: Clock select codes 0, 1, 2 and 3 give divisors of 8, 32, 128 and 512.
- R5: A tick that finds the counter equal to the constant clears the counter to 0x0000 and sets the match flag. With the constant at 0xFFFF, the counter rolls from 0xFFFF to 0x0000 and sets the flag.
- R6: Writing 0 to the run bit while it is 1 clears the counter to 0x0000.
- R7: The match flag is cleared only by writing 0 to bit 7 after the flag has been read as 1. A clearing write with no such read, or a write of 1, leaves the flag unchanged.
- R8: When a match occurs in the same cycle as a clearing write, the flag stays set.
- R9: The interrupt output is high exactly while both the match flag and the interrupt enable are 1.
- R10: A write to the counter takes priority over an increment or a match clear in the same cycle, and that cycle raises no match.
- R11: While module standby is high, the counter and the prescaler hold their values, register writes have no effect, and the constant keeps its contents. Reads still work.
- R12: While deep standby is high, the constant is forced to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 16 | Read data, combinational from the address while the read strobe is high |
| hold_i | input | 1 | Module standby: freezes the timer and blocks writes |
| sleep_i | input | 1 | Deep standby: restores the constant to all ones |
| irq_o | output | 1 | Interrupt, the match flag gated by the enable |

## Verification
The bench uses the default parameters: a 16-bit counter and a prescaler base of 2^3 with a step of 2^2. With these, all four divisors, up to the 512-cycle one, are checked within a few thousand cycles. The full 16-bit width still lets the 0xFFFF rollover be reached by preloading the counter instead of counting up to it. Small constants such as 0 and 3 put matches on known edges. This is how a match is made to land on the same edge as a clearing write or a counter write, and how the prescaler phase across a standby pause is shown to be preserved.

// File: rtl/mit_pkg.sv
package mit_pkg;
   localparam int unsigned REG_AW  = 2;
   localparam int unsigned CKS_W   = 2;
   localparam int unsigned NSEL    = 1 << CKS_W;
   localparam int unsigned FLAG_B  = 7;
   localparam int unsigned IE_B    = 6;

   typedef enum logic [REG_AW-1:0] {
      A_RUN = 2'd0,
      A_CSR = 2'd1,
      A_CNT = 2'd2,
      A_CMP = 2'd3
   } mit_addr_e;
endpackage

// File: rtl/mit_prescaler.sv
module mit_prescaler
   import mit_pkg::*;
#(
   parameter int unsigned PS_BASE = 3,
   parameter int unsigned PS_STEP = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             hold_i,
   input  logic [CKS_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int unsigned DIV_W = PS_BASE + PS_STEP * (NSEL - 1);

   if (PS_BASE < 1) begin : g_chk_base
      $error("mit_prescaler: PS_BASE must be at least 1");
   end
   if (PS_STEP < 1) begin : g_chk_step
      $error("mit_prescaler: PS_STEP must be at least 1");
   end

   logic [DIV_W-1:0] div_q;
   logic [NSEL-1:0]  tap;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      div_q <= '0;
      else if (clr_i)   div_q <= '0;
      else if (!hold_i) div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
   end

   for (genvar g = 0; g < NSEL; g++) begin : g_tap
      assign tap[g] = &div_q[PS_BASE + PS_STEP * g - 1 : 0];
   end

   assign tick_o = tap[sel_i] & ~hold_i & ~clr_i;
endmodule

// File: rtl/mit_counter.sv
module mit_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             stop_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             match_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   assign hit     = (cnt_q == cmp_i);
   assign match_o = tick_i & hit & ~wr_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (wr_i)    cnt_q <= wdata_i;
      else if (stop_i)  cnt_q <= '0;
      else if (tick_i)  cnt_q <= hit ? '0 : cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/mit_ctrl.sv
module mit_ctrl
   import mit_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_run_i,
   input  logic              wr_csr_i,
   input  logic              wr_cmp_i,
   input  logic              rd_csr_i,
   input  logic [CNT_W-1:0]  wdata_i,
   input  logic              match_i,
   input  logic              sleep_i,
   output logic              run_o,
   output logic              stop_o,
   output logic              ie_o,
   output logic              flag_o,
   output logic [CKS_W-1:0]  cks_o,
   output logic [CNT_W-1:0]  cmp_o
);
   logic             run_q, ie_q, flag_q, seen_q;
   logic [CKS_W-1:0] cks_q;
   logic [CNT_W-1:0] cmp_q;
   logic             clr_req;

   assign stop_o  = wr_run_i & ~wdata_i[0] & run_q;
   assign clr_req = wr_csr_i & ~wdata_i[FLAG_B] & seen_q & ~match_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         ie_q  <= 1'b0;
         cks_q <= '0;
      end else begin
         if (wr_run_i) run_q <= wdata_i[0];
         if (wr_csr_i) begin
            ie_q  <= wdata_i[IE_B];
            cks_q <= wdata_i[CKS_W-1:0];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         if (match_i)      flag_q <= 1'b1;
         else if (clr_req) flag_q <= 1'b0;
         if (clr_req)                  seen_q <= 1'b0;
         else if (rd_csr_i && flag_q)  seen_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cmp_q <= '1;
      else if (sleep_i)  cmp_q <= '1;
      else if (wr_cmp_i) cmp_q <= wdata_i;
   end

   assign run_o  = run_q;
   assign ie_o   = ie_q;
   assign flag_o = flag_q;
   assign cks_o  = cks_q;
   assign cmp_o  = cmp_q;
endmodule

// File: rtl/match_interval_timer.sv
module match_interval_timer
   import mit_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned PS_BASE = 3,
   parameter int unsigned PS_STEP = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [REG_AW-1:0] bus_addr_i,
   input  logic [CNT_W-1:0]  bus_wdata_i,
   input  logic              bus_we_i,
   input  logic              bus_re_i,
   output logic [CNT_W-1:0]  bus_rdata_o,
   input  logic              hold_i,
   input  logic              sleep_i,
   output logic              irq_o
);
   if (CNT_W < 8 || CNT_W > 32) begin : g_chk_w
      $error("match_interval_timer: CNT_W must lie in 8..32");
   end

   logic             wr_ok, cnt_wr, stop, run_q, ie_q, flag_q, tick, match_ev;
   logic [CKS_W-1:0] cks;
   logic [CNT_W-1:0] cnt_q, cmp_q;
   logic [CNT_W-1:0] csr_view;

   assign wr_ok  = bus_we_i & ~hold_i;
   assign cnt_wr = wr_ok & (bus_addr_i == A_CNT);

   mit_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_run_i (wr_ok & (bus_addr_i == A_RUN)),
      .wr_csr_i (wr_ok & (bus_addr_i == A_CSR)),
      .wr_cmp_i (wr_ok & (bus_addr_i == A_CMP)),
      .rd_csr_i (bus_re_i & (bus_addr_i == A_CSR)),
      .wdata_i  (bus_wdata_i),
      .match_i  (match_ev),
      .sleep_i  (sleep_i),
      .run_o    (run_q),
      .stop_o   (stop),
      .ie_o     (ie_q),
      .flag_o   (flag_q),
      .cks_o    (cks),
      .cmp_o    (cmp_q)
   );

   mit_prescaler #(.PS_BASE(PS_BASE), .PS_STEP(PS_STEP)) u_ps (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (~run_q),
      .hold_i (hold_i),
      .sel_i  (cks),
      .tick_o (tick)
   );

   mit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .stop_i  (stop),
      .wr_i    (cnt_wr),
      .wdata_i (bus_wdata_i),
      .cmp_i   (cmp_q),
      .cnt_o   (cnt_q),
      .match_o (match_ev)
   );

   always_comb begin
      csr_view               = '0;
      csr_view[FLAG_B]       = flag_q;
      csr_view[IE_B]         = ie_q;
      csr_view[CKS_W-1:0]    = cks;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_re_i) begin
         unique case (bus_addr_i)
            A_RUN:   bus_rdata_o = {{(CNT_W-1){1'b0}}, run_q};
            A_CSR:   bus_rdata_o = csr_view;
            A_CNT:   bus_rdata_o = cnt_q;
            default: bus_rdata_o = cmp_q;
         endcase
      end
   end

   assign irq_o = flag_q & ie_q;
endmodule

// File: rtl/mit_checker.sv
module mit_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             run_q,
   input logic             ie_q,
   input logic             flag_q,
   input logic             irq_o,
   input logic             hold_i,
   input logic             sleep_i,
   input logic             cnt_wr,
   input logic             match_ev,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] cmp_q
);
   // R3: without a counter write, the counter only steps by one, clears or holds
   a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_wr |=> (cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1})
                  || (cnt_q == '0) || (cnt_q == $past(cnt_q)));

   // R5: a match leaves the counter at zero and the flag set
   a_r5_match_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_ev |=> (cnt_q == '0) && flag_q);

   // R6: stopping leaves the counter at zero
   a_r6_stop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_q) |-> (cnt_q == '0));

   // R7: the flag only rises from a match
   a_r7_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q) |-> $past(match_ev));

   // R8: a match in the cycle of a clearing write keeps the flag
   a_r8_match_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_ev |=> flag_q);

   // R9: interrupt needs the enable, and the enabled flag drives it
   a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ie_q);
   a_r9_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && ie_q) |-> irq_o);

   // R11: module standby freezes counter and constant
   a_r11_standby_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_i && !sleep_i) |=> $stable(cnt_q) && $stable(cmp_q));

   // R12: deep standby restores the constant to all ones
   a_r12_sleep_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_i |=> (cmp_q == '1));
endmodule

bind match_interval_timer mit_checker #(.CNT_W(CNT_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .run_q    (run_q),
   .ie_q     (ie_q),
   .flag_q   (flag_q),
   .irq_o    (irq_o),
   .hold_i   (hold_i),
   .sleep_i  (sleep_i),
   .cnt_wr   (cnt_wr),
   .match_ev (match_ev),
   .cnt_q    (cnt_q),
   .cmp_q    (cmp_q)
);

// File: tb/sim_match_interval_timer.sv
`timescale 1ns/1ps
module sim_match_interval_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic        we = 1'b0, re = 1'b0, hold = 1'b0, sleep = 1'b0;
   logic [15:0] rdata;
   logic        irq;
   int          n_chk = 0, n_err = 0;
   bit          done = 1'b0;

   localparam logic [1:0] RUN = 2'd0, CSR = 2'd1, CNT = 2'd2, CMP = 2'd3;

   always #2.5 clk = ~clk;

   match_interval_timer u0 (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_we_i(we), .bus_re_i(re), .bus_rdata_o(rdata),
      .hold_i(hold), .sleep_i(sleep), .irq_o(irq));

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk); @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      addr = a; re = 1'b1;
      #1 v = rdata;
      @(posedge clk); @(negedge clk);
      re = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
      logic [15:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic clear_flag();
      logic [15:0] v;
      wr(RUN, 16'h0);
      rd(CSR, v);
      wr(CSR, 16'h0);
   endtask

   task automatic t_reset();
      chk("R1 irq", {15'd0, irq}, 16'h0);
      chk("R2 idle read data", rdata, 16'h0);
      rd_chk("R1 run", RUN, 16'h0);
      rd_chk("R1 csr", CSR, 16'h0);
      rd_chk("R1 counter", CNT, 16'h0);
      rd_chk("R1 constant", CMP, 16'hFFFF);
   endtask

   task automatic t_regs();
      wr(CMP, 16'hA5C3);
      rd_chk("R2 constant rw", CMP, 16'hA5C3);
      wr(CNT, 16'h1234);
      rd_chk("R2 counter rw", CNT, 16'h1234);
      wr(CSR, 16'h0043);
      rd_chk("R2 csr fields", CSR, 16'h0043);
      wr(CSR, 16'h0);
      wr(CNT, 16'h0);
      wr(CMP, 16'hFFFF);
   endtask

   task automatic t_prescale(input logic [1:0] sel, input int div, input int k);
      wr(CSR, {14'd0, sel});
      wr(RUN, 16'h1);
      repeat (k) @(negedge clk);
      rd_chk($sformatf("R3 R4 sel %0d after %0d edges", sel, k), CNT, 16'(k / div));
      wr(RUN, 16'h0);
      rd_chk("R6 stop clears counter", CNT, 16'h0);
   endtask

   task automatic t_match();
      wr(CSR, 16'h0);
      wr(CMP, 16'h0003);
      wr(RUN, 16'h1);
      repeat (31) @(negedge clk);
      rd_chk("R5 counter at constant", CNT, 16'h0003);
      rd_chk("R5 flag set on match", CSR, 16'h0080);
      chk("R9 irq off while disabled", {15'd0, irq}, 16'h0);
      rd_chk("R5 counter cleared", CNT, 16'h0000);
      wr(RUN, 16'h0);
      wr(CSR, 16'h00C0);
      rd_chk("R7 write of one keeps flag", CSR, 16'h00C0);
      chk("R9 irq on", {15'd0, irq}, 16'h1);
      wr(CSR, 16'h0040);
      rd_chk("R7 clear after read", CSR, 16'h0040);
      chk("R9 irq off after clear", {15'd0, irq}, 16'h0);
   endtask

   task automatic t_unread_clear();
      wr(RUN, 16'h1);
      repeat (40) @(negedge clk);
      wr(RUN, 16'h0);
      wr(CSR, 16'h0040);
      rd_chk("R7 unread clear ignored", CSR, 16'h00C0);
      chk("R9 irq follows flag", {15'd0, irq}, 16'h1);
      wr(CSR, 16'h0);
      rd_chk("R7 clear after read", CSR, 16'h0);
   endtask

   task automatic t_same_cycle();
      wr(CMP, 16'h0);
      wr(RUN, 16'h1);
      repeat (8) @(negedge clk);
      rd_chk("R5 match at zero constant", CSR, 16'h0080);
      repeat (6) @(negedge clk);
      wr(CSR, 16'h0);
      rd_chk("R8 match beats clear", CSR, 16'h0080);
      wr(RUN, 16'h0);
      wr(CSR, 16'h0);
      rd_chk("R8 later clear works", CSR, 16'h0);
   endtask

   task automatic t_wrap();
      wr(CMP, 16'hFFFF);
      wr(CNT, 16'hFFFE);
      wr(RUN, 16'h1);
      repeat (15) @(negedge clk);
      rd_chk("R5 reaches 0xFFFF", CNT, 16'hFFFF);
      rd_chk("R5 rollover sets flag", CSR, 16'h0080);
      rd_chk("R5 rollover to zero", CNT, 16'h0000);
      clear_flag();
   endtask

   task automatic t_priority();
      wr(RUN, 16'h1);
      repeat (7) @(negedge clk);
      wr(CNT, 16'h0050);
      rd_chk("R10 write beats increment", CNT, 16'h0050);
      wr(RUN, 16'h0);
   endtask

   task automatic t_standby();
      wr(CMP, 16'h0100);
      wr(RUN, 16'h1);
      repeat (20) @(negedge clk);
      hold = 1'b1;
      rd_chk("R11 count before hold", CNT, 16'h0002);
      repeat (50) @(negedge clk);
      wr(CMP, 16'h0007);
      wr(RUN, 16'h0);
      rd_chk("R11 counter held", CNT, 16'h0002);
      rd_chk("R11 constant kept", CMP, 16'h0100);
      rd_chk("R11 run write ignored", RUN, 16'h0001);
      hold = 1'b0;
      repeat (4) @(negedge clk);
      rd_chk("R11 prescaler phase kept", CNT, 16'h0003);
      wr(RUN, 16'h0);
   endtask

   task automatic t_sleep();
      wr(CMP, 16'h1357);
      sleep = 1'b1;
      @(negedge clk);
      sleep = 1'b0;
      rd_chk("R12 deep standby restores constant", CMP, 16'hFFFF);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_prescale(2'd0, 8, 7);
      t_prescale(2'd0, 8, 20);
      t_prescale(2'd1, 32, 100);
      t_prescale(2'd2, 128, 300);
      t_prescale(2'd3, 512, 1030);
      t_match();
      t_unread_clear();
      t_same_cycle();
      t_wrap();
      t_priority();
      t_standby();
      t_sleep();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule